// File: doc/BRIEF.md
# Partitioned Reorder Buffer Size Manager

This block sets the active length of a circular reorder buffer whose storage is split into equal partitions of 16 slots each. By default there are eight partitions, so up to 128 slots. The block owns the allocation pointer (the next free slot, which moves on dispatch) and the retirement pointer (the oldest slot, which moves on commit). It also keeps an occupancy count, so it can tell a full buffer from an empty one. Both pointers wrap at the current active length.

A policy elsewhere decides when the buffer should grow or shrink by one partition, and it raises a grow or shrink request. The block accepts at most one such request at a time. It holds the request until the pointers are in a position where the change cannot cut off a live entry. Then it applies the new length and updates the partition enables that gate the storage. While a shrink is waiting, the block holds dispatch at the new boundary so that nothing is written into a partition that is about to be switched off.

Top module: `rob_resize_mgr`

## Requirements
- R1: After reset, all partitions are enabled and the active size is 128. Both pointers are 0, occupancy is 0, and no resize is pending.
- R2: An accepted dispatch (`disp_ok`) is `disp_req` with the buffer not full and `disp_stall` low. An accepted commit (`commit_ok`) is `commit_req` with occupancy non-zero, outside a resize-apply cycle. Each accepted operation moves its pointer by one, and the pointer goes from active size minus 1 back to 0.
- R3: Occupancy rises by one for each accepted dispatch and falls by one for each accepted commit, and it never exceeds the active size. While occupancy equals the active size, `disp_ok` is low.
- R4: A request is taken only when no resize is pending. Grow is taken only below the maximum size, and shrink only above the minimum (1 partition). If both are raised together, grow wins. A request that is not taken has no effect: `resize_pending` stays low, or it keeps the direction already held.
- R5: A pending grow is applied in the first cycle in which tail + occupancy ≤ active size, meaning the live region does not wrap. If that region ends exactly at the old size, the head pointer moves to the old size. A pending grow never blocks dispatch except in its one apply cycle.
- R6: A pending shrink is applied in the first cycle in which tail + occupancy ≤ active size − 16. At that point, any pointer that equals the new size is set to 0.
- R7: While a shrink is pending and the head pointer equals active size − 16, `disp_stall` is high.
- R8: In the apply cycle, `disp_stall` is high and no commit is accepted. The new size and the cleared pending flag appear at the following clock edge. The active size changes at no other time.
- R9: `part_en` enables the lowest active size / 16 partitions and no others. Both pointers always lie below the active size, so no live entry sits in a disabled partition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_req | input | 1 | Request to allocate one slot at the head |
| commit_req | input | 1 | Request to retire one slot at the tail |
| grow_req | input | 1 | Ask to add one partition |
| shrink_req | input | 1 | Ask to remove one partition |
| disp_ok | output | 1 | Dispatch accepted this cycle |
| commit_ok | output | 1 | Commit accepted this cycle |
| disp_stall | output | 1 | Dispatch held by the resize logic |
| head_ptr | output | 7 | Next free slot |
| tail_ptr | output | 7 | Oldest live slot |
| occupancy | output | 8 | Number of live slots |
| active_size | output | 8 | Current active length in slots |
| part_en | output | 8 | Enable per partition, bit 0 is the lowest |
| resize_pending | output | 1 | A resize is waiting to be applied |
| pending_grow | output | 1 | The pending resize is a grow |

## Verification
`disp_ok`, `commit_ok` and `disp_stall` are combinational from the present state and inputs, so they are due in the same cycle as the stimulus. Pointers, occupancy and the pending flags are due at the next rising edge. A taken request can apply no earlier than the cycle after it was taken, and its new size shows at the edge after the apply cycle. The bench drives inputs on the falling edge and compares all outputs 2 ns later against a cycle model built from the requirements. It advances that model only after the rising edge, so every check lands in the cycle where its value is due.

// File: rtl/rob_rsz_pkg.sv
`timescale 1ns/1ps
package rob_rsz_pkg;
   typedef enum logic [1:0] {
      RSZ_IDLE   = 2'd0,
      RSZ_GROW   = 2'd1,
      RSZ_SHRINK = 2'd2
   } rsz_op_e;
endpackage

// File: rtl/rob_rsz_ptr.sv
`timescale 1ns/1ps
// Circular pointer that wraps at a run-time limit and can be reloaded.
module rob_rsz_ptr #(
   parameter int PTR_W  = 7,
   parameter int SIZE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              load,
   input  logic [PTR_W-1:0]  load_val,
   input  logic [SIZE_W-1:0] limit,
   output logic [PTR_W-1:0]  ptr
);
   logic [SIZE_W-1:0] ptr_inc;
   assign ptr_inc = SIZE_W'(ptr) + SIZE_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)       ptr <= '0;
      else if (load)    ptr <= load_val;
      else if (adv)     ptr <= (ptr_inc == limit) ? '0 : PTR_W'(ptr_inc);
   end
endmodule

// File: rtl/rob_rsz_part_en.sv
`timescale 1ns/1ps
// Thermometer decode of the active partition count.
module rob_rsz_part_en #(
   parameter int NUM_PARTS = 8,
   parameter int CNT_W     = 4
) (
   input  logic [CNT_W-1:0]     parts,
   output logic [NUM_PARTS-1:0] en
);
   for (genvar g = 0; g < NUM_PARTS; g++) begin : g_en
      assign en[g] = (parts > CNT_W'(g));
   end
endmodule

// File: rtl/rob_rsz_ctrl.sv
`timescale 1ns/1ps
// Resize request holding, safe-point detection and size register.
module rob_rsz_ctrl
   import rob_rsz_pkg::*;
#(
   parameter int NUM_PARTS    = 8,
   parameter int PART_ENTRIES = 16,
   parameter int MIN_PARTS    = 1,
   parameter int PTR_W        = 7,
   parameter int SIZE_W       = 8,
   parameter int CNT_W        = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grow_req,
   input  logic              shrink_req,
   input  logic [PTR_W-1:0]  head,
   input  logic [PTR_W-1:0]  tail,
   input  logic [SIZE_W-1:0] occ,
   output logic [CNT_W-1:0]  parts,
   output logic [SIZE_W-1:0] size,
   output rsz_op_e           op,
   output logic              apply,
   output logic              bnd_stall,
   output logic [PTR_W-1:0]  head_new,
   output logic [PTR_W-1:0]  tail_new
);
   localparam int LIN_W   = SIZE_W + 1;
   localparam int PART_SH = $clog2(PART_ENTRIES);

   logic [LIN_W-1:0]  lin_end;
   logic [SIZE_W-1:0] shr_size;
   logic              safe_grow, safe_shrink, head_at_bnd, tail_at_bnd;

   assign size        = SIZE_W'(parts) << PART_SH;
   assign shr_size    = size - SIZE_W'(PART_ENTRIES);
   assign lin_end     = LIN_W'(tail) + LIN_W'(occ);
   assign safe_grow   = lin_end <= LIN_W'(size);
   assign safe_shrink = lin_end <= LIN_W'(shr_size);
   assign head_at_bnd = SIZE_W'(head) == shr_size;
   assign tail_at_bnd = SIZE_W'(tail) == shr_size;

   assign apply     = ((op == RSZ_GROW) && safe_grow) || ((op == RSZ_SHRINK) && safe_shrink);
   assign bnd_stall = (op == RSZ_SHRINK) && head_at_bnd;

   always_comb begin
      head_new = head;
      tail_new = tail;
      if (op == RSZ_GROW) begin
         if (lin_end == LIN_W'(size)) head_new = PTR_W'(size);
      end else begin
         if (head_at_bnd) head_new = '0;
         if (tail_at_bnd) tail_new = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         parts <= CNT_W'(NUM_PARTS);
         op    <= RSZ_IDLE;
      end else if (apply) begin
         parts <= (op == RSZ_GROW) ? parts + CNT_W'(1) : parts - CNT_W'(1);
         op    <= RSZ_IDLE;
      end else if (op == RSZ_IDLE) begin
         if (grow_req && (parts < CNT_W'(NUM_PARTS)))       op <= RSZ_GROW;
         else if (shrink_req && (parts > CNT_W'(MIN_PARTS))) op <= RSZ_SHRINK;
      end
   end
endmodule

// File: rtl/rob_resize_mgr.sv
`timescale 1ns/1ps
module rob_resize_mgr
   import rob_rsz_pkg::*;
#(
   parameter int NUM_PARTS    = 8,
   parameter int PART_ENTRIES = 16,
   parameter int MIN_PARTS    = 1,
   localparam int DEPTH  = NUM_PARTS * PART_ENTRIES,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int SIZE_W = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 disp_req,
   input  logic                 commit_req,
   input  logic                 grow_req,
   input  logic                 shrink_req,
   output logic                 disp_ok,
   output logic                 commit_ok,
   output logic                 disp_stall,
   output logic [PTR_W-1:0]     head_ptr,
   output logic [PTR_W-1:0]     tail_ptr,
   output logic [SIZE_W-1:0]    occupancy,
   output logic [SIZE_W-1:0]    active_size,
   output logic [NUM_PARTS-1:0] part_en,
   output logic                 resize_pending,
   output logic                 pending_grow
);
   localparam int CNT_W = $clog2(NUM_PARTS + 1);

   if (PART_ENTRIES < 2 || (PART_ENTRIES & (PART_ENTRIES - 1)) != 0) begin : g_bad_pe
      $error("PART_ENTRIES must be a power of two of at least 2");
   end
   if (NUM_PARTS < 2) begin : g_bad_np
      $error("NUM_PARTS must be at least 2");
   end
   if (MIN_PARTS < 1 || MIN_PARTS >= NUM_PARTS) begin : g_bad_min
      $error("MIN_PARTS must lie in [1, NUM_PARTS-1]");
   end

   logic [CNT_W-1:0] parts;
   rsz_op_e          op;
   logic             apply, bnd_stall, full;
   logic [PTR_W-1:0] head_new, tail_new;

   rob_rsz_ctrl #(
      .NUM_PARTS(NUM_PARTS), .PART_ENTRIES(PART_ENTRIES), .MIN_PARTS(MIN_PARTS),
      .PTR_W(PTR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .grow_req(grow_req), .shrink_req(shrink_req),
      .head(head_ptr), .tail(tail_ptr), .occ(occupancy),
      .parts(parts), .size(active_size), .op(op), .apply(apply),
      .bnd_stall(bnd_stall), .head_new(head_new), .tail_new(tail_new)
   );

   assign full       = occupancy == active_size;
   assign disp_stall = apply | bnd_stall;
   assign disp_ok    = disp_req & ~full & ~disp_stall;
   assign commit_ok  = commit_req & (occupancy != '0) & ~apply;

   rob_rsz_ptr #(.PTR_W(PTR_W), .SIZE_W(SIZE_W)) u_head (
      .clk(clk), .rst_n(rst_n), .adv(disp_ok), .load(apply),
      .load_val(head_new), .limit(active_size), .ptr(head_ptr)
   );

   rob_rsz_ptr #(.PTR_W(PTR_W), .SIZE_W(SIZE_W)) u_tail (
      .clk(clk), .rst_n(rst_n), .adv(commit_ok), .load(apply),
      .load_val(tail_new), .limit(active_size), .ptr(tail_ptr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) occupancy <= '0;
      else if (disp_ok && !commit_ok) occupancy <= occupancy + SIZE_W'(1);
      else if (!disp_ok && commit_ok) occupancy <= occupancy - SIZE_W'(1);
   end

   rob_rsz_part_en #(.NUM_PARTS(NUM_PARTS), .CNT_W(CNT_W)) u_en (
      .parts(parts), .en(part_en)
   );

   assign resize_pending = op != RSZ_IDLE;
   assign pending_grow   = op == RSZ_GROW;
endmodule

// File: rtl/rob_resize_mgr_chk.sv
`timescale 1ns/1ps
module rob_resize_mgr_chk #(
   parameter int NUM_PARTS    = 8,
   parameter int PART_ENTRIES = 16,
   localparam int DEPTH  = NUM_PARTS * PART_ENTRIES,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int SIZE_W = $clog2(DEPTH + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 disp_ok,
   input logic                 commit_ok,
   input logic                 disp_stall,
   input logic [PTR_W-1:0]     head_ptr,
   input logic [PTR_W-1:0]     tail_ptr,
   input logic [SIZE_W-1:0]    occupancy,
   input logic [SIZE_W-1:0]    active_size,
   input logic [NUM_PARTS-1:0] part_en,
   input logic                 resize_pending,
   input logic                 pending_grow
);
   localparam logic [SIZE_W-1:0] PE = SIZE_W'(PART_ENTRIES);

   p_commit_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      commit_ok |-> occupancy != '0);

   p_occ_le_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy <= active_size);

   p_no_disp_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (occupancy == active_size) |-> !disp_ok);

   p_pend_clears_with_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(resize_pending) |-> !$stable(active_size));

   p_grow_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(active_size) && $past(pending_grow)) |-> active_size == $past(active_size) + PE);

   p_shrink_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(active_size) && !$past(pending_grow)) |-> active_size == $past(active_size) - PE);

   p_shrink_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (resize_pending && !pending_grow && (SIZE_W'(head_ptr) == active_size - PE)) |-> disp_stall);

   p_size_only_on_apply_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active_size) |-> $fell(resize_pending));

   p_part_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(part_en) * PART_ENTRIES == int'(active_size)) && part_en[0]);

   p_ptrs_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (SIZE_W'(head_ptr) < active_size) && (SIZE_W'(tail_ptr) < active_size));
endmodule

bind rob_resize_mgr rob_resize_mgr_chk #(
   .NUM_PARTS(NUM_PARTS), .PART_ENTRIES(PART_ENTRIES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .disp_ok(disp_ok), .commit_ok(commit_ok),
   .disp_stall(disp_stall), .head_ptr(head_ptr), .tail_ptr(tail_ptr),
   .occupancy(occupancy), .active_size(active_size), .part_en(part_en),
   .resize_pending(resize_pending), .pending_grow(pending_grow)
);

// File: tb/rob_resize_mgr_tb.sv
`timescale 1ns/1ps
module rob_resize_mgr_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       disp_req = 1'b0, commit_req = 1'b0, grow_req = 1'b0, shrink_req = 1'b0;
   logic       disp_ok, commit_ok, disp_stall, resize_pending, pending_grow;
   logic [6:0] head_ptr, tail_ptr;
   logic [7:0] occupancy, active_size;
   logic [7:0] part_en;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // model state
   int m_size = 128, m_head = 0, m_tail = 0, m_occ = 0, m_pend = 0;
   string ptr_tag = "R2";

   always #10 clk = ~clk;

   rob_resize_mgr u_dut (
      .clk(clk), .rst_n(rst_n), .disp_req(disp_req), .commit_req(commit_req),
      .grow_req(grow_req), .shrink_req(shrink_req), .disp_ok(disp_ok),
      .commit_ok(commit_ok), .disp_stall(disp_stall), .head_ptr(head_ptr),
      .tail_ptr(tail_ptr), .occupancy(occupancy), .active_size(active_size),
      .part_en(part_en), .resize_pending(resize_pending), .pending_grow(pending_grow)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   function automatic int therm(int sz);
      return (1 << (sz / 16)) - 1;
   endfunction

   // one cycle: drive, compare against model, advance model at the edge
   task automatic step(bit dr, bit cr, bit gr, bit sr);
      int lin, ns, dok, cok;
      bit app, stl, full;
      @(negedge clk);
      disp_req = dr; commit_req = cr; grow_req = gr; shrink_req = sr;
      #2;
      lin  = m_tail + m_occ;
      ns   = m_size - 16;
      app  = (m_pend == 1 && lin <= m_size) || (m_pend == 2 && lin <= ns);
      stl  = app || (m_pend == 2 && m_head == ns);
      full = (m_occ == m_size);
      dok  = (dr && !full && !stl) ? 1 : 0;
      cok  = (cr && m_occ != 0 && !app) ? 1 : 0;
      chk(app ? "R8 stall" : (m_pend == 2 ? "R7 stall" : "R5 stall"), int'(disp_stall), int'(stl));
      chk(full ? "R3 disp_ok" : "R2 disp_ok", int'(disp_ok), dok);
      chk(app ? "R8 commit_ok" : "R2 commit_ok", int'(commit_ok), cok);
      chk({ptr_tag, " head"}, int'(head_ptr), m_head);
      chk({ptr_tag, " tail"}, int'(tail_ptr), m_tail);
      chk("R3 occupancy", int'(occupancy), m_occ);
      chk("R8 active_size", int'(active_size), m_size);
      chk("R9 part_en", int'(part_en), therm(m_size));
      chk("R4 pending", int'(resize_pending), (m_pend != 0) ? 1 : 0);
      chk("R4 pending_grow", int'(pending_grow), (m_pend == 1) ? 1 : 0);
      @(posedge clk);
      if (app) begin
         if (m_pend == 1) begin
            if (lin == m_size) m_head = m_size;
            m_size += 16;
            ptr_tag = "R5";
         end else begin
            if (m_head == ns) m_head = 0;
            if (m_tail == ns) m_tail = 0;
            m_size = ns;
            ptr_tag = "R6";
         end
         m_pend = 0;
      end else begin
         if (dok != 0) m_head = (m_head + 1 == m_size) ? 0 : m_head + 1;
         if (cok != 0) m_tail = (m_tail + 1 == m_size) ? 0 : m_tail + 1;
         m_occ += dok - cok;
         if (m_pend == 0) begin
            if (gr && m_size < 128) m_pend = 1;
            else if (sr && m_size > 16) m_pend = 2;
         end
         ptr_tag = "R2";
      end
   endtask

   function automatic bit pct(int p);
      return ($urandom % 100) < p;
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R1 reset state
      chk("R1 active_size", int'(active_size), 128);
      chk("R1 part_en", int'(part_en), 255);
      chk("R1 head", int'(head_ptr), 0);
      chk("R1 tail", int'(tail_ptr), 0);
      chk("R1 occupancy", int'(occupancy), 0);
      chk("R1 pending", int'(resize_pending), 0);

      // R4: grow at maximum is ignored
      step(0, 0, 1, 0);
      step(0, 0, 0, 0);
      // R3: fill to full, dispatch refused
      for (int i = 0; i < 132; i++) step(1, 0, 0, 0);
      // R6/R7: shrink requested while full, then drain slowly with dispatch pressure
      step(0, 0, 0, 1);
      // R4: opposite request while pending is ignored
      step(0, 0, 1, 0);
      for (int i = 0; i < 400 && m_pend != 0; i++) step(1, pct(60), 0, 0);
      // shrink down to the minimum with commit-heavy traffic
      for (int i = 0; i < 6000 && m_size > 16; i++) step(pct(40), pct(90), 0, 1);
      step(0, 0, 0, 0);
      // R4: shrink at minimum is ignored
      step(0, 0, 0, 1);
      step(0, 0, 0, 0);
      // R5: grow back up while the region is wrapped
      for (int i = 0; i < 6000 && m_size < 128; i++) step(pct(70), pct(60), 1, 0);
      // mixed random traffic and requests
      for (int blk = 0; blk < 40; blk++) begin
         int pd, pc;
         pd = 20 + int'($urandom % 80);
         pc = 20 + int'($urandom % 80);
         for (int i = 0; i < 500; i++)
            step(pct(pd), pct(pc), pct(3), pct(3));
      end
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 190000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule